// File: doc/BRIEF.md
# I2C Target with Two Output-Code Registers

This block is a bus target on a two-wire serial bus. It holds two 8-bit output codes, A and B, that the rest of the chip uses as configuration values. A bus controller writes new codes and reads back the stored state. SCL and SDA are sampled on the system clock. Each line passes through a two-flop synchroniser and then a three-sample agreement filter. START, STOP and clock edges are found from the filtered levels. The block never drives SCL. It only pulls SDA low, through an open-drain enable, to acknowledge and to send read data.

Each written data byte carries a destination in bits 7:6 and a 6-bit code in bits 5:0. The two top bits are stored once and appear as bits 7:6 of both codes. A written value does not take effect at once. It waits in a staging copy until a commit counter expires, which stands in for a slow non-volatile store. A busy flag stays high during the wait, and a one-cycle pulse marks the moment the outputs change.

A read returns code A first, then code B, then a snapshot of an external input port. The read can stop after any byte. The target's 7-bit address is picked from two fixed values by a strap input.

Top module: `i2c_dual_code_port`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new transaction. A STOP (SDA rising while SCL is high) ends any transaction. A read stopped after its first byte returns only code A, and the next read starts again at code A.
- R2: The target acknowledges address 1001110 when `addr_sel` is 1 and 0110111 when `addr_sel` is 0. The address byte is sent MSB first and its bit 0 is the read flag (1 = read). To acknowledge, the target pulls SDA low during the ninth clock.
- R3: No other address gets an acknowledge, including the general call 0000000 and the address of the other strap setting. After a non-matching address the target leaves SDA released and changes nothing until the next START.
- R4: Every write data byte is acknowledged. When bits 7:6 of the byte are 00, bits 5:0 become the low six bits of code A. When they are 01, bits 5:0 become the low six bits of code B.
- R5: Bits 7:6 of `code_a` and `code_b` are one shared field. It takes bits 7:6 of the last written byte, whichever register that byte addressed. A byte whose bits 7:6 are 10 or 11 changes only this shared field.
- R6: After reset, both codes are 0x00 and `busy` is low. A write sets `busy` and starts a count of `COMMIT_CYC` cycles. Until the count ends, `code_a` and `code_b` keep their old values. A further write during the wait restarts the count, and all staged changes then commit together.
- R7: `commit_pulse` is high for exactly one cycle. It occurs in the cycle in which `busy` falls and the outputs take the staged values.
- R8: A read returns code A, then code B, then the input port zero-extended to 8 bits. Any further bytes repeat that port value. The port is captured once, when the read address is acknowledged.
- R9: When the controller NACKs a read byte, the target releases SDA. It does not drive SDA again until the next START.
- R10: Reads do not change the codes, the staged values or `busy`.
- R11: The target begins pulling SDA low only while SCL is low.
- R12: A pulse on SCL or SDA that lasts fewer than three clock cycles has no effect on the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| addr_sel | input | 1 | Strap that picks one of the two bus addresses |
| port_in | input | PORT_W | External input port, returned as the third read byte |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| code_a | output | 8 | Committed code A |
| code_b | output | 8 | Committed code B |
| busy | output | 1 | A written value is waiting to commit |
| commit_pulse | output | 1 | One-cycle pulse when staged values take effect |

## Verification
The bench writes each destination code under both strap settings, including bytes with 10 and 11 in the top bits. A design that wrote the code field on such bytes, or kept two separate select fields, would show the wrong top bits on the other register. A second write is issued halfway through the commit wait. A design that did not restart the count would update the outputs early and would be caught. Reads run past the port byte, and the port changes after the address phase. A design that wrapped back to code A, or that sampled the port late, would return the wrong bytes. The general call, the other strap's address and a two-cycle SCL glitch inside a data byte are also sent. These expose an unwanted acknowledge, or a byte that has shifted by one bit.

// File: rtl/i2c_dual_code_port.sv
`timescale 1ns/1ps
module i2c_dual_code_port #(
  parameter int COMMIT_CYC = 1250000,
  parameter int PORT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  input  logic [PORT_W-1:0] port_in,
  output logic              sda_oe,
  output logic [7:0]        code_a,
  output logic [7:0]        code_b,
  output logic              busy,
  output logic              commit_pulse
);
  localparam int TW = $clog2(COMMIT_CYC + 1);
  localparam logic [6:0] ADDR_HI = 7'b1001110;
  localparam logic [6:0] ADDR_LO = 7'b0110111;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK, S_WAIT} st_t;
  st_t state;

  logic [1:0] scl_s, sda_s;
  logic [2:0] scl_h, sda_h;
  logic       scl_f, sda_f, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[1:0], scl_s[1]};
      sda_h <= {sda_h[1:0], sda_s[1]};
      if (scl_h == 3'b111) scl_f <= 1'b1; else if (scl_h == 3'b000) scl_f <= 1'b0;
      if (sda_h == 3'b111) sda_f <= 1'b1; else if (sda_h == 3'b000) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire start_c = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c  = scl_f & scl_q & ~sda_q & sda_f;
  wire rise    = scl_f & ~scl_q;
  wire fall    = ~scl_f & scl_q;

  logic [7:0] sh, tx, snap, port_byte, nbyte;
  logic [3:0] cnt;
  logic [1:0] idx, nidx;
  logic       rw, nack;

  always_comb begin
    port_byte = '0;
    port_byte[PORT_W-1:0] = port_in;
    nidx  = (idx == 2'd2) ? 2'd2 : idx + 2'd1;
    nbyte = (nidx == 2'd1) ? code_b : snap;
  end

  wire match = sh[7:1] == (addr_sel ? ADDR_HI : ADDR_LO);
  wire wr_ev = (state == S_WR) && fall && cnt == 4'd8 && !start_c && !stop_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sh <= '0; tx <= '0; snap <= '0; cnt <= '0;
      idx <= '0; rw <= 1'b0; nack <= 1'b0; sda_oe <= 1'b0;
    end else if (start_c) begin
      state <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_WR: begin
          if (rise) begin
            sh  <= {sh[6:0], sda_f};
            cnt <= cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            if (state == S_WR) begin
              sda_oe <= 1'b1; state <= S_WACK;
            end else if (match) begin
              sda_oe <= 1'b1; rw <= sh[0]; state <= S_AACK;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        S_AACK: if (fall) begin
          cnt <= '0;
          if (rw) begin
            idx <= '0; snap <= port_byte; tx <= code_a;
            sda_oe <= ~code_a[7]; state <= S_RD;
          end else begin
            sda_oe <= 1'b0; state <= S_WR;
          end
        end
        S_WACK: if (fall) begin
          sda_oe <= 1'b0; cnt <= '0; state <= S_WR;
        end
        S_RD: if (fall) begin
          if (cnt == 4'd7) begin
            sda_oe <= 1'b0; state <= S_RACK;
          end else begin
            tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; cnt <= cnt + 4'd1;
          end
        end
        S_RACK: begin
          if (rise) nack <= sda_f;
          else if (fall) begin
            if (nack) state <= S_WAIT;
            else begin
              idx <= nidx; tx <= nbyte; sda_oe <= ~nbyte[7];
              cnt <= '0; state <= S_RD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  logic [1:0]    st_sel, cm_sel;
  logic [5:0]    st_a, st_b, cm_a, cm_b;
  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sel <= '0; st_a <= '0; st_b <= '0;
      cm_sel <= '0; cm_a <= '0; cm_b <= '0;
      timer <= '0; busy <= 1'b0; commit_pulse <= 1'b0;
    end else begin
      commit_pulse <= 1'b0;
      if (wr_ev) begin
        st_sel <= sh[7:6];
        if (sh[7:6] == 2'b00) st_a <= sh[5:0];
        if (sh[7:6] == 2'b01) st_b <= sh[5:0];
        busy  <= 1'b1;
        timer <= TW'(COMMIT_CYC - 1);
      end else if (busy) begin
        if (timer == '0) begin
          cm_sel <= st_sel; cm_a <= st_a; cm_b <= st_b;
          busy <= 1'b0; commit_pulse <= 1'b1;
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end

  assign code_a = {cm_sel, cm_a};
  assign code_b = {cm_sel, cm_b};
endmodule

// File: rtl/i2c_dual_code_port_chk.sv
`timescale 1ns/1ps
module i2c_dual_code_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       busy,
  input logic       commit_pulse,
  input logic [7:0] code_a,
  input logic [7:0] code_b
);
  assert_commit_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (!busy && $past(busy)));

  assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  assert_busy_drops_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> commit_pulse);

  assert_codes_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |-> ($stable(code_a) && $stable(code_b)));

  assert_sda_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c_dual_code_port i2c_dual_code_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy(busy),
  .commit_pulse(commit_pulse), .code_a(code_a), .code_b(code_b)
);

// File: tb/sim_i2c_dual_code_port.sv
`timescale 1ns/1ps
module sim_i2c_dual_code_port;
  localparam int COMMIT = 2000;
  localparam int Q = 16;
  localparam logic [6:0] A_HI = 7'b1001110;
  localparam logic [6:0] A_LO = 7'b0110111;
  // {addr_sel, written byte, expected code_a, expected code_b}
  localparam logic [24:0] VEC [6] = '{
    {1'b1, 8'h15, 8'h15, 8'h00},
    {1'b0, 8'h6A, 8'h55, 8'h6A},
    {1'b1, 8'h80, 8'h95, 8'hAA},
    {1'b0, 8'hFF, 8'hD5, 8'hEA},
    {1'b1, 8'h3F, 8'h3F, 8'h2A},
    {1'b0, 8'h41, 8'h7F, 8'h41}
  };

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda_low = 1'b0, addr_sel = 1'b1;
  logic [4:0] port_in = '0;
  logic sda_oe, busy, commit_pulse;
  logic [7:0] code_a, code_b;
  wire sda_line = ~(m_sda_low | sda_oe);
  int total = 0, bad = 0, r11_viol = 0;
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  i2c_dual_code_port #(.COMMIT_CYC(COMMIT), .PORT_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .addr_sel(addr_sel),
    .port_in(port_in), .sda_oe(sda_oe), .code_a(code_a), .code_b(code_b),
    .busy(busy), .commit_pulse(commit_pulse));

  always @(negedge clk) begin
    if (rst_n && m_scl && sda_oe && !prev_oe) r11_viol++;
    prev_oe <= sda_oe;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    m_sda_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
    m_sda_low = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda_low = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda_low = 1'b0; wq(Q);
  endtask

  task automatic put_bit(input logic b, input logic glitch);
    m_sda_low = ~b; wq(Q / 2);
    if (glitch) begin m_scl = 1'b1; wq(2); m_scl = 1'b0; end
    wq(Q / 2); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
    b = sda_line; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] d, input logic glitch, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], glitch && i == 4);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(input logic m_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(~m_ack, 1'b0);
  endtask

  task automatic wait_idle;
    for (int n = 0; n < 3 * COMMIT && busy; n++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack, b;
    logic [7:0] d, pa, pb;
    wq(5); rst_n = 1'b1; wq(5);
    check("R6 reset code_a", code_a, 8'h00);
    check("R6 reset code_b", code_b, 8'h00);
    check("R6 reset busy", busy, 1'b0);
    check("R9 reset sda_oe", sda_oe, 1'b0);

    for (int i = 0; i < 6; i++) begin
      addr_sel = VEC[i][24]; pa = code_a; pb = code_b;
      i2c_start;
      wr_byte({addr_sel ? A_HI : A_LO, 1'b0}, 1'b0, ack);
      check("R2 address ack", ack, 1'b1);
      wr_byte(VEC[i][23:16], 1'b0, ack);
      check("R4 data ack", ack, 1'b1);
      i2c_stop;
      check("R6 busy after write", busy, 1'b1);
      check("R6 code_a held", code_a, pa);
      check("R6 code_b held", code_b, pb);
      wait_idle; wq(2);
      check("R5 code_a after commit", code_a, VEC[i][15:8]);
      check("R4 code_b after commit", code_b, VEC[i][7:0]);
    end

    // full read, port changes after address phase
    addr_sel = 1'b0; port_in = 5'h13;
    i2c_start;
    wr_byte({A_LO, 1'b1}, 1'b0, ack);
    check("R2 read address ack", ack, 1'b1);
    port_in = 5'h0A;
    rd_byte(1'b1, d); check("R8 byte0 code A", d, 8'h7F);
    rd_byte(1'b1, d); check("R8 byte1 code B", d, 8'h41);
    rd_byte(1'b1, d); check("R8 byte2 port", d, 8'h13);
    rd_byte(1'b1, d); check("R8 byte3 repeat port", d, 8'h13);
    rd_byte(1'b0, d); check("R8 byte4 repeat port", d, 8'h13);
    for (int k = 0; k < 9; k++) begin
      get_bit(b); check("R9 released after nack", b, 1'b1);
    end
    i2c_stop;
    check("R10 code_a after read", code_a, 8'h7F);
    check("R10 code_b after read", code_b, 8'h41);
    check("R10 busy after read", busy, 1'b0);

    // stop after first byte, then fresh read restarts at A
    addr_sel = 1'b1;
    i2c_start; wr_byte({A_HI, 1'b1}, 1'b0, ack);
    rd_byte(1'b0, d); check("R1 single byte read", d, 8'h7F);
    i2c_stop;
    i2c_start; wr_byte({A_HI, 1'b1}, 1'b0, ack);
    rd_byte(1'b1, d); check("R1 restart at code A", d, 8'h7F);
    rd_byte(1'b0, d); check("R1 then code B", d, 8'h41);
    i2c_stop;

    // addresses that must be ignored
    i2c_start; wr_byte({A_LO, 1'b0}, 1'b0, ack);
    check("R3 other strap address nack", ack, 1'b0);
    wr_byte(8'h00, 1'b0, ack);
    check("R3 data after mismatch nack", ack, 1'b0);
    i2c_stop;
    i2c_start; wr_byte({7'b0000000, 1'b0}, 1'b0, ack);
    check("R3 general call nack", ack, 1'b0);
    i2c_stop;
    check("R3 busy unchanged", busy, 1'b0);
    check("R3 code_a unchanged", code_a, 8'h7F);

    // restart of commit count
    i2c_start; wr_byte({A_HI, 1'b0}, 1'b0, ack); wr_byte(8'h01, 1'b0, ack); i2c_stop;
    wq(200);
    i2c_start; wr_byte({A_HI, 1'b0}, 1'b0, ack); wr_byte(8'h42, 1'b0, ack); i2c_stop;
    wq(700);
    check("R6 restart keeps busy", busy, 1'b1);
    check("R6 restart holds code_a", code_a, 8'h7F);
    wait_idle; wq(2);
    check("R6 combined code_a", code_a, 8'h41);
    check("R6 combined code_b", code_b, 8'h42);

    // SCL glitch inside a data byte
    i2c_start; wr_byte({A_HI, 1'b0}, 1'b0, ack);
    wr_byte(8'h2B, 1'b1, ack);
    check("R12 ack with glitch", ack, 1'b1);
    i2c_stop;
    wait_idle; wq(2);
    check("R12 code_a after glitch", code_a, 8'h2B);
    check("R5 code_b shared field", code_b, 8'h02);

    check("R11 sda pulled only with scl low", r11_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule